// File: doc/BRIEF.md
# Slave Clock Holdover Controller

This block supervises a slave oscillator that follows a reference from the level above it. It watches two reference inputs, a preferred (active) one and a backup (standby) one, and picks one of them. It also watches the lock flag and the frequency-control word coming from an external phase detector and loop filter. A three-state machine decides which frequency word reaches the oscillator.

The three states are lock, hold and free. In lock the live word is passed through and a copy of it is kept. In hold the kept copy is applied unchanged. In free a fixed nominal word is applied.

Entry into lock needs the lock flag and a valid reference to persist for a programmable number of timebase ticks. Hold ages out to free after a programmable number of ticks. Reference selection is revertive: the active input is chosen whenever it is valid.

Top module: `holdover_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `state_o` is free (code 0), `freq_o` equals the parameter `NOMINAL`, and `sel_ref` is 0 (the active reference). The other codes are lock = 1 and hold = 2.
- R2: On each clock edge `sel_ref` becomes 0 if `ref_a_ok` is high, becomes 1 if only `ref_b_ok` is high, and keeps its value if neither is high. When the active reference recovers, selection returns to it one clock later.
- R3: From free or hold, the controller enters lock at the edge where a tick arrives and the condition "`pd_lock` high and at least one reference valid" has been seen on `qual_len` consecutive ticks, counting this one. A `qual_len` of 0 behaves as 1. Any cycle without that condition clears the count.
- R4: In lock, `freq_o` equals `pd_word` in the same cycle.
- R5: In lock, if both references are invalid or `pd_lock` is low, the state is hold one clock later.
- R6: In hold, `freq_o` is frozen at the value of `pd_word` captured at the last edge taken in lock with `pd_lock` high, or at the edge of entry into lock. Changes on `pd_word` have no effect.
- R7: In hold, a tick counter starts at zero on entry. The controller moves to free at the edge where that tick count reaches `hold_limit`, or at the first tick when `hold_limit` is 0. An entry into lock on the same tick takes priority.
- R8: In free, `freq_o` equals `NOMINAL` whatever `pd_word` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe, one cycle wide |
| ref_a_ok | input | 1 | Active reference is valid |
| ref_b_ok | input | 1 | Standby reference is valid |
| pd_lock | input | 1 | Phase detector reports lock |
| pd_word | input | FW | Frequency word from the loop |
| qual_len | input | QW | Ticks of steady lock needed to enter lock |
| hold_limit | input | CW | Maximum ticks spent in hold |
| sel_ref | output | 1 | Selected reference: 0 active, 1 standby |
| state_o | output | 2 | State: 0 free, 1 lock, 2 hold |
| freq_o | output | FW | Frequency word applied to the oscillator |

## Verification
The bench keeps the default widths (16-bit word, 16-bit hold counter, 8-bit qualification counter) with a nominal word of 0x8000. It drives `qual_len` at 3 so that a broken run of lock ticks is visible as a missing transition. It later lowers `qual_len` to 0 to reach the immediate-entry case. It sets `hold_limit` first to 8, so that a re-lock inside hold can be seen, and then to 2, so that the age-out to free is reached within a few ticks.

// File: rtl/holdover_ctrl.sv
module holdover_ctrl #(
  parameter int unsigned FW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned QW = 8,
  parameter logic [FW-1:0] NOMINAL = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ref_a_ok,
  input  logic          ref_b_ok,
  input  logic          pd_lock,
  input  logic [FW-1:0] pd_word,
  input  logic [QW-1:0] qual_len,
  input  logic [CW-1:0] hold_limit,
  output logic          sel_ref,
  output logic [1:0]    state_o,
  output logic [FW-1:0] freq_o
);

  localparam logic [1:0] ST_FREE = 2'd0;
  localparam logic [1:0] ST_LOCK = 2'd1;
  localparam logic [1:0] ST_HOLD = 2'd2;

  logic [1:0]    state;
  logic [FW-1:0] held_word;
  logic [QW-1:0] qcnt;
  logic [CW-1:0] hcnt;

  wire any_ok = ref_a_ok | ref_b_ok;
  wire good   = any_ok & pd_lock;

  wire [QW:0] qnext = {1'b0, qcnt} + 1'b1;
  wire [CW:0] hnext = {1'b0, hcnt} + 1'b1;

  wire qual_done   = tick & good & (qnext >= {1'b0, qual_len});
  wire hold_expire = tick & (hnext >= {1'b0, hold_limit});

  assign state_o = state;
  assign freq_o  = (state == ST_LOCK) ? pd_word :
                   (state == ST_HOLD) ? held_word : NOMINAL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ref <= 1'b0;
    end else if (ref_a_ok) begin
      sel_ref <= 1'b0;
    end else if (ref_b_ok) begin
      sel_ref <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '0;
    end else if (state == ST_LOCK || !good || qual_done) begin
      qcnt <= '0;
    end else if (tick && qcnt != '1) begin
      qcnt <= qcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else if (state != ST_HOLD) begin
      hcnt <= '0;
    end else if (tick && hcnt != '1) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FREE;
      held_word <= NOMINAL;
    end else begin
      case (state)
        ST_LOCK: begin
          if (pd_lock) held_word <= pd_word;
          if (!good) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (qual_done) begin
            state     <= ST_LOCK;
            held_word <= pd_word;
          end else if (hold_expire) begin
            state <= ST_FREE;
          end
        end
        default: begin
          if (qual_done) begin
            state     <= ST_LOCK;
            held_word <= pd_word;
          end
        end
      endcase
    end
  end

  AST_REVERT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_a_ok |=> (sel_ref == 1'b0)); // R2

  AST_LOCK_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_LOCK && $past(state_o) != ST_LOCK) |-> $past(tick && pd_lock && (ref_a_ok || ref_b_ok))); // R3

  AST_LOSS_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_LOCK && !(ref_a_ok || ref_b_ok)) |=> (state_o == ST_HOLD)); // R5

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HOLD && $past(state_o) == ST_HOLD) |-> $stable(freq_o)); // R6

  AST_FREE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FREE && $past(state_o) == ST_HOLD) |-> $past(tick)); // R7

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3); // R1

endmodule

// File: tb/sim_holdover_ctrl.sv
module sim_holdover_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ref_a_ok = 1'b0;
  logic        ref_b_ok = 1'b0;
  logic        pd_lock = 1'b0;
  logic [15:0] pd_word = 16'h0;
  logic [7:0]  qual_len = 8'd3;
  logic [15:0] hold_limit = 16'd8;
  logic        sel_ref;
  logic [1:0]  state_o;
  logic [15:0] freq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]  q_state[$];
  logic        q_sel[$];
  logic [15:0] q_freq[$];
  string       q_tag[$];

  localparam logic [15:0] NOM = 16'h8000;
  localparam logic [1:0] F = 2'd0, L = 2'd1, H = 2'd2;

  holdover_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_a_ok(ref_a_ok), .ref_b_ok(ref_b_ok),
    .pd_lock(pd_lock), .pd_word(pd_word), .qual_len(qual_len), .hold_limit(hold_limit),
    .sel_ref(sel_ref), .state_o(state_o), .freq_o(freq_o)
  );

  always #5 clk = ~clk;

  task automatic step(input logic a, input logic b, input logic lk, input logic [15:0] w,
                      input logic tk, input logic [1:0] es, input logic esel,
                      input logic [15:0] ef, input string tag);
    @(posedge clk);
    #2;
    ref_a_ok = a; ref_b_ok = b; pd_lock = lk; pd_word = w; tick = tk;
    q_state.push_back(es); q_sel.push_back(esel); q_freq.push_back(ef); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q_state.size() > 0) begin
      logic [1:0] es;
      logic esel;
      logic [15:0] ef;
      string tag;
      es = q_state.pop_front(); esel = q_sel.pop_front();
      ef = q_freq.pop_front(); tag = q_tag.pop_front();
      checks++;
      if (state_o !== es) begin
        errors++;
        $display("FAIL %s state actual=%0d expected=%0d", tag, state_o, es);
      end
      checks++;
      if (sel_ref !== esel) begin
        errors++;
        $display("FAIL %s sel_ref actual=%0d expected=%0d", tag, sel_ref, esel);
      end
      checks++;
      if (freq_o !== ef) begin
        errors++;
        $display("FAIL %s freq actual=%h expected=%h", tag, freq_o, ef);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (state_o !== F || freq_o !== NOM || sel_ref !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset actual=%0d/%h/%0d expected=0/%h/0", state_o, freq_o, sel_ref, NOM);
    end
    rst_n = 1'b1;
    // R1 first cycle after reset
    step(0,0,0,16'h1111,1, F,0,NOM, "R1");
    step(0,1,1,16'h1234,1, F,0,NOM, "R2_keep");
    step(0,1,1,16'h1234,0, F,1,NOM, "R2_standby");
    step(0,1,1,16'h1234,1, F,1,NOM, "R8_free");
    step(0,1,1,16'h1234,1, F,1,NOM, "R3_count");
    step(1,1,1,16'h2222,0, L,1,16'h2222, "R3_R4_lock");
    step(1,0,1,16'h3333,0, L,0,16'h3333, "R2_revert");
    step(0,0,1,16'h4444,0, L,0,16'h4444, "R4");
    step(0,0,0,16'h5555,1, H,0,16'h4444, "R5_R6");
    step(0,1,1,16'h6666,1, H,0,16'h4444, "R6_frozen");
    step(0,1,1,16'h6666,1, H,1,16'h4444, "R6");
    step(0,1,0,16'h6666,1, H,1,16'h4444, "R3_break");
    step(0,1,1,16'h6666,1, H,1,16'h4444, "R3_restart");
    step(0,1,1,16'h6666,1, H,1,16'h4444, "R3_no_early");
    step(0,1,1,16'h6666,1, H,1,16'h4444, "R3_hold_count");
    hold_limit = 16'd2;
    step(1,0,0,16'h7777,0, L,1,16'h7777, "R3_relock_R4");
    step(1,0,0,16'h9999,1, H,0,16'h6666, "R5_lockdrop_R6");
    step(1,0,0,16'h9999,0, H,0,16'h6666, "R7_wait");
    step(1,0,0,16'h9999,1, H,0,16'h6666, "R7_wait2");
    step(1,0,0,16'h9999,0, F,0,NOM, "R7_R8");
    qual_len = 8'd0;
    step(1,0,1,16'hAAAA,1, F,0,NOM, "R8");
    step(1,0,1,16'hBBBB,0, L,0,16'hBBBB, "R3_zero_qual");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule